// File: doc/BRIEF.md
# Accumulator Operate Micro-op Unit

This block executes the register-only "operate" class of instructions for a 12-bit accumulator machine. The class is recognised by opcode 7 in the top three instruction bits together with a zero in instruction bit 8. One instruction word can request several micro-operations at once: clearing, complementing, incrementing, rotating and half-swapping the accumulator (AC) and the one-bit link (L). The unit applies them in a fixed order.

The surrounding core presents the instruction word, the current AC and link, and an execute strobe. One clock edge after a strobe, the outputs hold the updated AC and link. For a word outside the operate class, the outputs hold the input AC and link unchanged. Without a strobe the outputs keep their value.

Top module: `g1_opr_unit`

## Requirements
- R1: While reset (rst_n low) is applied, acc_o and link_o go to 0 at the next clock edge.
- R2: The result of an instruction appears on acc_o/link_o one clock edge after exec_i is sampled high. While exec_i is low, acc_o and link_o hold their value whatever the other inputs do.
- R3: A word is handled by the unit only when bits [11:9] equal octal 7 and bit 8 is 0. For any other word, an executed strobe copies acc_i and link_i unchanged to the outputs.
- R4: Bit 7 (octal 0200) clears AC and bit 6 (0100) clears L. Both clears act before the complements, so clear plus complement yields all ones.
- R5: Bit 5 (0040) replaces AC with its 12-bit ones' complement, and bit 4 (0020) inverts L. The complements act before the increment.
- R6: Bit 0 (0001) adds one to AC modulo 4096. When AC wraps from 7777 to 0000, L is inverted; otherwise L is not touched by the increment.
- R7: Bit 3 (0010) rotates the 13-bit value {L, AC} right by one: bit 0 of AC goes into L, and L goes into AC bit 11. The rotate acts after the increment.
- R8: Bit 2 (0004) rotates {L, AC} left by one: AC bit 11 goes into L, and L goes into AC bit 0.
- R9: When bit 1 (0002) is set together with exactly one rotate bit, that rotate is applied twice.
- R10: Bit 1 with neither rotate bit exchanges AC bits [5:0] and [11:6], after clear, complement and increment. L is unaffected by the exchange.
- R11: A word with both rotate bits (3 and 2) set is undefined. Executing it leaves the outputs equal to acc_i and link_i, whatever other bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute strobe; one instruction per high cycle |
| insn_i | input | 12 | Instruction word |
| acc_i | input | W (12) | Current accumulator |
| link_i | input | 1 | Current link bit |
| acc_o | output | W (12) | Registered accumulator result |
| link_o | output | 1 | Registered link result |

## Verification
The bench builds the unit with the default accumulator width of 12, which is the width the instruction encoding and the octal corner values (7777 wrap, 4000 rotate-out, half exchange of 0123) are defined for. At this width, every combination of the eight micro-op bits can be reached by the random words. The directed cases cover the carry into the link, rotation through the link in both directions, and the ordering of clear, complement and increment ahead of the rotates.

// File: rtl/g1_opr_pkg.sv
package g1_opr_pkg;

    localparam int INSN_W = 12;
    localparam logic [2:0] OPC_OPERATE = 3'o7;

    // instruction bit positions
    localparam int OPC_LSB  = 9;
    localparam int GRP_BIT  = 8;
    localparam int B_CLRA   = 7;
    localparam int B_CLRL   = 6;
    localparam int B_INVA   = 5;
    localparam int B_INVL   = 4;
    localparam int B_ROTR   = 3;
    localparam int B_ROTL   = 2;
    localparam int B_DBL    = 1;
    localparam int B_INCR   = 0;

    typedef struct packed {
        logic active;
        logic clr_acc;
        logic clr_lnk;
        logic inv_acc;
        logic inv_lnk;
        logic incr;
        logic rot_r;
        logic rot_l;
        logic dbl;
    } g1_ctl_t;

endpackage

// File: rtl/g1_opr_decode.sv
module g1_opr_decode
    import g1_opr_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output g1_ctl_t           ctl
);

    logic in_class;
    logic both_rot;

    always_comb begin
        in_class    = (insn[INSN_W-1:OPC_LSB] == OPC_OPERATE) && !insn[GRP_BIT];
        both_rot    = insn[B_ROTR] && insn[B_ROTL];
        ctl.active  = in_class && !both_rot;
        ctl.clr_acc = insn[B_CLRA];
        ctl.clr_lnk = insn[B_CLRL];
        ctl.inv_acc = insn[B_INVA];
        ctl.inv_lnk = insn[B_INVL];
        ctl.incr    = insn[B_INCR];
        ctl.rot_r   = insn[B_ROTR];
        ctl.rot_l   = insn[B_ROTL];
        ctl.dbl     = insn[B_DBL];
    end

endmodule

// File: rtl/g1_opr_alu.sv
module g1_opr_alu #(
    parameter int W = 12
) (
    input  logic         clr_acc,
    input  logic         clr_lnk,
    input  logic         inv_acc,
    input  logic         inv_lnk,
    input  logic         incr,
    input  logic [W-1:0] acc,
    input  logic         lnk,
    output logic [W-1:0] acc_o,
    output logic         lnk_o
);

    logic [W-1:0] a_clr, a_inv;
    logic         l_clr, l_inv;
    logic [W:0]   sum;

    always_comb begin
        a_clr = clr_acc ? '0 : acc;
        l_clr = clr_lnk ? 1'b0 : lnk;
        a_inv = inv_acc ? ~a_clr : a_clr;
        l_inv = inv_lnk ? ~l_clr : l_clr;
        sum   = {1'b0, a_inv} + {{W{1'b0}}, incr};
        acc_o = sum[W-1:0];
        lnk_o = l_inv ^ sum[W];
    end

endmodule

// File: rtl/g1_opr_shift.sv
module g1_opr_shift #(
    parameter int W      = 12,
    parameter int PASSES = 2
) (
    input  logic         rot_r,
    input  logic         rot_l,
    input  logic         dbl,
    input  logic [W-1:0] acc,
    input  logic         lnk,
    output logic [W-1:0] acc_o,
    output logic         lnk_o
);

    localparam int HALF = W / 2;

    logic [PASSES:0][W:0] stg;
    logic                 any_rot;

    assign any_rot = rot_r | rot_l;
    assign stg[0]  = {lnk, acc};

    for (genvar k = 0; k < PASSES; k++) begin : g_pass
        logic en;
        assign en = any_rot && ((k == 0) || dbl);
        assign stg[k+1] = !en  ? stg[k] :
                          rot_r ? {stg[k][0], stg[k][W:1]} :
                                  {stg[k][W-1:0], stg[k][W]};
    end

    always_comb begin
        if (!any_rot && dbl) begin
            acc_o = {acc[HALF-1:0], acc[W-1:HALF]};
            lnk_o = lnk;
        end else begin
            acc_o = stg[PASSES][W-1:0];
            lnk_o = stg[PASSES][W];
        end
    end

endmodule

// File: rtl/g1_opr_unit.sv
module g1_opr_unit
    import g1_opr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [W-1:0]      acc_i,
    input  logic              link_i,
    output logic [W-1:0]      acc_o,
    output logic              link_o
);

    typedef struct packed {
        logic [W-1:0] acc;
        logic         lnk;
    } arch_t;

    g1_ctl_t      ctl;
    logic [W-1:0] alu_acc, sh_acc;
    logic         alu_lnk, sh_lnk;
    arch_t        st_d, st_q;

    g1_opr_decode u_dec (
        .insn (insn_i),
        .ctl  (ctl)
    );

    g1_opr_alu #(.W(W)) u_alu (
        .clr_acc (ctl.clr_acc),
        .clr_lnk (ctl.clr_lnk),
        .inv_acc (ctl.inv_acc),
        .inv_lnk (ctl.inv_lnk),
        .incr    (ctl.incr),
        .acc     (acc_i),
        .lnk     (link_i),
        .acc_o   (alu_acc),
        .lnk_o   (alu_lnk)
    );

    g1_opr_shift #(.W(W), .PASSES(2)) u_sh (
        .rot_r (ctl.rot_r),
        .rot_l (ctl.rot_l),
        .dbl   (ctl.dbl),
        .acc   (alu_acc),
        .lnk   (alu_lnk),
        .acc_o (sh_acc),
        .lnk_o (sh_lnk)
    );

    always_comb begin
        st_d = st_q;
        if (exec_i) begin
            if (ctl.active) begin
                st_d.acc = sh_acc;
                st_d.lnk = sh_lnk;
            end else begin
                st_d.acc = acc_i;
                st_d.lnk = link_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o  = st_q.acc;
    assign link_o = st_q.lnk;

endmodule

// File: rtl/g1_opr_chk.sv
module g1_opr_chk #(
    parameter int W = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_i,
    input logic [11:0]   insn_i,
    input logic [W-1:0]  acc_i,
    input logic          link_i,
    input logic [W-1:0]  acc_o,
    input logic          link_o
);

    logic sel;
    assign sel = (insn_i[11:9] == 3'o7) && !insn_i[8];

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0) && !link_o);

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(acc_o) && $stable(link_o));

    p_foreign_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !sel) |=> (acc_o == $past(acc_i)) && (link_o == $past(link_i)));

    p_clear_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && insn_i == 12'o7300) |=> (acc_o == '0) && !link_o);

    p_invert_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && insn_i == 12'o7040) |=> (acc_o == ~$past(acc_i)) && (link_o == $past(link_i)));

    p_wrap_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && insn_i == 12'o7001 && acc_i == '1) |=> (acc_o == '0) && (link_o == !$past(link_i)));

    p_dual_rot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && sel && insn_i[3] && insn_i[2]) |=> (acc_o == $past(acc_i)) && (link_o == $past(link_i)));

endmodule

bind g1_opr_unit g1_opr_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_i (exec_i),
    .insn_i (insn_i),
    .acc_i  (acc_i),
    .link_i (link_i),
    .acc_o  (acc_o),
    .link_o (link_o)
);

// File: tb/tb_g1_opr_unit.sv
module tb_g1_opr_unit;

    localparam int W          = 12;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_i = 1'b0;
    logic [11:0]   insn_i = '0;
    logic [W-1:0]  acc_i = '0;
    logic          link_i = 1'b0;
    logic [W-1:0]  acc_o;
    logic          link_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    g1_opr_unit #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec_i (exec_i),
        .insn_i (insn_i),
        .acc_i  (acc_i),
        .link_i (link_i),
        .acc_o  (acc_o),
        .link_o (link_o)
    );

    // reference model built from the requirement list
    function automatic logic [W:0] ref_model(input logic [11:0] w, input logic [W-1:0] a_in, input logic l_in);
        logic [W-1:0] a;
        logic         l;
        logic [W:0]   t;
        int           reps;
        a = a_in;
        l = l_in;
        if (w[11:9] != 3'o7 || w[8]) return {l_in, a_in};
        if (w[3] && w[2]) return {l_in, a_in};
        if (w[7]) a = 0;
        if (w[6]) l = 0;
        if (w[5]) a = a ^ {W{1'b1}};
        if (w[4]) l = !l;
        if (w[0]) begin
            a = a + 1;
            if (a == 0) l = !l;
        end
        reps = w[1] ? 2 : 1;
        t = {l, a};
        if (w[3]) begin
            for (int i = 0; i < reps; i++) t = {t[0], t[W:1]};
        end else if (w[2]) begin
            for (int i = 0; i < reps; i++) t = {t[W-1:0], t[W]};
        end else if (w[1]) begin
            t = {l, a[5:0], a[11:6]};
        end
        return t;
    endfunction

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got link=%0b acc=%04o, expected link=%0b acc=%04o",
                     req, got[W], got[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic run_op(input string req, input logic [11:0] w, input logic [W-1:0] a,
                          input logic l, input logic [W:0] exp);
        @(negedge clk);
        insn_i = w; acc_i = a; link_i = l; exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
        check(req, {link_o, acc_o}, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL R2: watchdog expired, got no completion, expected end of run");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {link_o, acc_o}, '0);
        rst_n = 1'b1;

        run_op("R4 clear AC and link", 12'o7300, 12'o5555, 1'b1, {1'b0, 12'o0000});
        run_op("R4 clear then complement AC", 12'o7240, 12'o1234, 1'b0, {1'b0, 12'o7777});
        run_op("R4 clear then complement link", 12'o7120, 12'o0042, 1'b0, {1'b1, 12'o0042});
        run_op("R5 complement AC", 12'o7040, 12'o0000, 1'b1, {1'b1, 12'o7777});
        run_op("R5 complement link", 12'o7020, 12'o0777, 1'b1, {1'b0, 12'o0777});
        run_op("R6 increment wraps, link flips", 12'o7001, 12'o7777, 1'b0, {1'b1, 12'o0000});
        run_op("R6 increment no wrap", 12'o7001, 12'o0005, 1'b1, {1'b1, 12'o0006});
        run_op("R7 rotate right into link", 12'o7010, 12'o0001, 1'b0, {1'b1, 12'o0000});
        run_op("R7 increment before rotate right", 12'o7211, 12'o3333, 1'b0, {1'b1, 12'o0000});
        run_op("R8 rotate left into link", 12'o7004, 12'o4000, 1'b0, {1'b1, 12'o0000});
        run_op("R9 double rotate left", 12'o7006, 12'o0001, 1'b1, {1'b0, 12'o0006});
        run_op("R9 double rotate right", 12'o7012, 12'o0002, 1'b1, {1'b1, 12'o2000});
        run_op("R10 half exchange", 12'o7002, 12'o0123, 1'b1, {1'b1, 12'o2301});
        run_op("R11 both rotates leave state", 12'o7314, 12'o4321, 1'b1, {1'b1, 12'o4321});
        run_op("R3 bit 8 set passes through", 12'o7400, 12'o1111, 1'b1, {1'b1, 12'o1111});
        run_op("R3 other opcode passes through", 12'o1201, 12'o7777, 1'b0, {1'b0, 12'o7777});

        // R2: hold with exec low while inputs change
        held = {link_o, acc_o};
        @(negedge clk);
        insn_i = 12'o7300; acc_i = 12'o6543; link_i = ~link_i;
        @(negedge clk);
        check("R2 hold while idle", {link_o, acc_o}, held);

        // constrained random mix
        void'($urandom(32'd20221016));
        for (int i = 0; i < 400; i++) begin
            logic [11:0] w;
            logic [W-1:0] a;
            logic l;
            w = 12'($urandom);
            if (($urandom % 10) < 8) w = {3'o7, 1'b0, w[7:0]};
            a = W'($urandom);
            if (($urandom % 8) == 0) a = '1;
            l = 1'($urandom);
            run_op("R3-R11 random op", w, a, l, ref_model(w, a, l));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule